// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Guard Bits

This block multiplies two 16-bit operands every clock and loads, adds or subtracts the product into a 40-bit accumulator register. The accumulator has eight guard bits above a 32-bit working range, so long sums can go past 32 bits without losing their value. Each operand is read as two's complement or as unsigned, chosen per operand on every cycle. There is no stall. An operation presented with the valid strobe is visible on the accumulator output one clock later.

Two read-out paths work combinationally off the accumulator register. The 32-bit path can saturate. The 16-bit path takes the upper half of the 32-bit range, can round it first, and can saturate. A sticky overflow flag records that the accumulator left the 32-bit signed range. The flag is a two-state machine. In state OVF_CLEAR it moves to OVF_SET on any update that leaves the accumulator outside the signed 32-bit range. In OVF_SET it stays there until the clear strobe moves it back to OVF_CLEAR. The `ovf` output is high in OVF_SET.

Top module: `frac_mac`

## Requirements
- R1: The product is a times b. An operand whose `a_sgn`/`b_sgn` bit is 1 is read as two's complement, and an operand whose bit is 0 is read as unsigned. All four combinations give the exact product.
- R2: `op` encodes the update: 2'b00 loads the product, 2'b01 adds the product, 2'b10 subtracts the product, and 2'b11 leaves the accumulator unchanged. With `in_valid` high at a rising edge, the new value appears on `acc` right after that edge.
- R3: With `in_valid` low and `clr` low, the accumulator keeps its value.
- R4: `clr` high at a rising edge sets the accumulator to zero and drops `ovf`. It takes priority over `in_valid`. Reset gives the same state.
- R5: The accumulator wraps modulo 2^40.
- R6: `ovf` rises in the same cycle the accumulator takes a value whose bits [39:31] are not all equal. It then stays high until `clr`.
- R7: `ext32` equals acc[31:0]. When `sat_en` is 1 and bits [39:31] are not all equal, `ext32` is instead 0x7FFFFFFF if acc[39] is 0 and 0x80000000 if acc[39] is 1.
- R8: When `rnd_en` is 1, 0x8000 is added to the sign-extended accumulator before bits [31:16] are taken. Ties therefore round toward plus infinity. When `rnd_en` is 0, no value is added.
- R9: When `sat_en` is 1 and the possibly rounded value lies outside the signed 32-bit range, `ext16` is 0x7FFF for a positive value and 0x8000 for a negative one. Otherwise `ext16` is bits [31:16] of that value.
- R10: An operation given on every consecutive cycle is applied each time, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Apply `op` at this edge |
| clr | input | 1 | Zero the accumulator and the overflow flag |
| op | input | 2 | Update select (load, add, subtract, none) |
| a_sgn | input | 1 | Operand a is two's complement |
| b_sgn | input | 1 | Operand b is two's complement |
| a | input | 16 | Operand a |
| b | input | 16 | Operand b |
| rnd_en | input | 1 | Round the 16-bit extract |
| sat_en | input | 1 | Saturate the extracts |
| acc | output | 40 | Accumulator value |
| ext32 | output | 32 | 32-bit extract |
| ext16 | output | 16 | 16-bit extract |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach from the ports are a true 40-bit wrap and a rounding carry that pushes a value sitting just under the 32-bit limit into saturation. The first needs roughly 130 maximum-size unsigned products in a row. The second needs an accumulator of exactly 0x7FFF8000. Both are reached by dedicated runs. Long chains of 0xFFFF by 0xFFFF additions, and then subtractions, walk through the guard bits and past the wrap point. A short load-then-add sequence builds 0x7FFF8000 exactly, and the rounding and saturation enables are then toggled on it. A sweep over corner operands, all sign modes, all operation codes and both read-out options covers everything else. In that sweep, valid-low cycles and clear strobes are mixed in.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
    typedef enum logic [1:0] {
        MAC_LOAD = 2'b00,
        MAC_ADD  = 2'b01,
        MAC_SUB  = 2'b10,
        MAC_HOLD = 2'b11
    } mac_op_e;

    typedef enum logic {
        OVF_CLEAR = 1'b0,
        OVF_SET   = 1'b1
    } ovf_state_e;
endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
    parameter int OPW   = 16,
    localparam int PRODW = 2 * OPW + 2
) (
    input  logic [OPW-1:0]          a,
    input  logic [OPW-1:0]          b,
    input  logic                    a_sgn,
    input  logic                    b_sgn,
    output logic signed [PRODW-1:0] prod
);
    // One extra top bit per operand lets a single signed multiplier
    // handle unsigned inputs as well (R1).
    logic signed [OPW:0] a_x;
    logic signed [OPW:0] b_x;

    always_comb begin
        a_x  = {a_sgn & a[OPW-1], a};
        b_x  = {b_sgn & b[OPW-1], b};
        prod = PRODW'(a_x) * PRODW'(b_x);
    end
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum
    import frac_mac_pkg::*;
#(
    parameter int ACCW  = 40,
    parameter int PRODW = 34,
    parameter int RESW  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   in_valid,
    input  mac_op_e                op,
    input  logic signed [PRODW-1:0] prod,
    output logic [ACCW-1:0]        acc,
    output logic                   ovf
);
    localparam int HIW = ACCW - RESW + 1;

    logic [ACCW-1:0] prod_x;
    logic [ACCW-1:0] acc_q;
    logic [ACCW-1:0] acc_nxt;
    logic [HIW-1:0]  hi_nxt;
    logic            oor_nxt;
    ovf_state_e      state_q;
    ovf_state_e      state_nxt;

    assign prod_x = {{(ACCW-PRODW){prod[PRODW-1]}}, prod};

    // Next accumulator value; the add and subtract wrap in ACCW bits (R5).
    always_comb begin
        acc_nxt = acc_q;
        if (clr) begin
            acc_nxt = '0;
        end else if (in_valid) begin
            unique case (op)
                MAC_LOAD: acc_nxt = prod_x;
                MAC_ADD:  acc_nxt = acc_q + prod_x;
                MAC_SUB:  acc_nxt = acc_q - prod_x;
                MAC_HOLD: acc_nxt = acc_q;
            endcase
        end
        hi_nxt  = acc_nxt[ACCW-1:RESW-1];
        oor_nxt = !((&hi_nxt) || !(|hi_nxt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_nxt;
    end

    // Overflow flag state machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_CLEAR;
        else        state_q <= state_nxt;
    end

    // Transitions: OVF_CLEAR -> OVF_SET on an out-of-range update,
    // OVF_SET -> OVF_CLEAR on clr.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            OVF_CLEAR: if (!clr && oor_nxt) state_nxt = OVF_SET;
            OVF_SET:   if (clr)             state_nxt = OVF_CLEAR;
        endcase
    end

    // Outputs.
    always_comb begin
        acc = acc_q;
        ovf = (state_q == OVF_SET);
    end

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0) && !ovf);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (!in_valid || op == MAC_HOLD)) |=> $stable(acc_q));

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_valid && op == MAC_LOAD) |=> acc_q == $past(prod_x));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    a_r6_flag_cover: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |-> ((&acc_q[ACCW-1:RESW-1]) || !(|acc_q[ACCW-1:RESW-1])));
endmodule

// File: rtl/fmac_extract.sv
module fmac_extract #(
    parameter int ACCW = 40,
    parameter int RESW = 32,
    parameter int OUTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ACCW-1:0] acc,
    input  logic            rnd_en,
    input  logic            sat_en,
    output logic [RESW-1:0] ext32,
    output logic [OUTW-1:0] ext16
);
    localparam int FRACW = RESW - OUTW;
    localparam logic [RESW-1:0] MAX_R = {1'b0, {(RESW-1){1'b1}}};
    localparam logic [RESW-1:0] MIN_R = {1'b1, {(RESW-1){1'b0}}};
    localparam logic [OUTW-1:0] MAX_O = {1'b0, {(OUTW-1){1'b1}}};
    localparam logic [OUTW-1:0] MIN_O = {1'b1, {(OUTW-1){1'b0}}};
    localparam logic [ACCW:0]   HALF  = {{(ACCW-FRACW+1){1'b0}}, 1'b1, {(FRACW-1){1'b0}}};

    logic [ACCW:0] rnd_sum;
    logic          oor_acc;
    logic          oor_rnd;

    // One extra bit keeps the rounding carry from wrapping the sign (R8).
    always_comb begin
        rnd_sum = {acc[ACCW-1], acc} + (rnd_en ? HALF : '0);
        oor_acc = !((&acc[ACCW-1:RESW-1]) || !(|acc[ACCW-1:RESW-1]));
        oor_rnd = !((&rnd_sum[ACCW:RESW-1]) || !(|rnd_sum[ACCW:RESW-1]));

        if (sat_en && oor_acc) ext32 = acc[ACCW-1] ? MIN_R : MAX_R;
        else                   ext32 = acc[RESW-1:0];

        if (sat_en && oor_rnd) ext16 = rnd_sum[ACCW] ? MIN_O : MAX_O;
        else                   ext16 = rnd_sum[RESW-1:FRACW];
    end

    a_r7_sat_sign: assert property (@(posedge clk) disable iff (!rst_n)
        sat_en |-> ext32[RESW-1] == acc[ACCW-1]);

    a_r9_sat_sign: assert property (@(posedge clk) disable iff (!rst_n)
        sat_en |-> ext16[OUTW-1] == rnd_sum[ACCW]);
endmodule

// File: rtl/frac_mac.sv
module frac_mac
    import frac_mac_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int GRDW = 8,
    parameter int RESW = 2 * OPW,
    localparam int ACCW  = RESW + GRDW,
    localparam int PRODW = 2 * OPW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            clr,
    input  logic [1:0]      op,
    input  logic            a_sgn,
    input  logic            b_sgn,
    input  logic [OPW-1:0]  a,
    input  logic [OPW-1:0]  b,
    input  logic            rnd_en,
    input  logic            sat_en,
    output logic [ACCW-1:0] acc,
    output logic [RESW-1:0] ext32,
    output logic [OPW-1:0]  ext16,
    output logic            ovf
);
    logic signed [PRODW-1:0] prod;
    mac_op_e                 op_e;

    assign op_e = mac_op_e'(op);

    fmac_mult #(.OPW(OPW)) u_mult (
        .a     (a),
        .b     (b),
        .a_sgn (a_sgn),
        .b_sgn (b_sgn),
        .prod  (prod)
    );

    fmac_accum #(.ACCW(ACCW), .PRODW(PRODW), .RESW(RESW)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .op       (op_e),
        .prod     (prod),
        .acc      (acc),
        .ovf      (ovf)
    );

    fmac_extract #(.ACCW(ACCW), .RESW(RESW), .OUTW(OPW)) u_extract (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .rnd_en (rnd_en),
        .sat_en (sat_en),
        .ext32  (ext32),
        .ext16  (ext16)
    );
endmodule

// File: tb/frac_mac_tb_top.sv
`timescale 1ns/1ps
module frac_mac_tb_top;
    localparam longint MAXP = 64'sd2147483647;
    localparam longint MINN = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        a_sgn = 1'b0;
    logic        b_sgn = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        rnd_en = 1'b0;
    logic        sat_en = 1'b0;
    logic [39:0] acc;
    logic [31:0] ext32;
    logic [15:0] ext16;
    logic        ovf;

    int     vectors = 0;
    int     miscmp  = 0;
    bit     done    = 0;
    longint m_acc   = 0;
    bit     m_ovf   = 0;

    always #4 clk = ~clk;

    frac_mac dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr(clr), .op(op),
        .a_sgn(a_sgn), .b_sgn(b_sgn), .a(a), .b(b), .rnd_en(rnd_en),
        .sat_en(sat_en), .acc(acc), .ext32(ext32), .ext16(ext16), .ovf(ovf)
    );

    function automatic longint sx40(longint v);
        logic [39:0] t;
        t = v[39:0];
        return {{24{t[39]}}, t};
    endfunction

    function automatic bit oor32(longint v);
        return (v > MAXP) || (v < MINN);
    endfunction

    function automatic logic [15:0] corner(int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h00FF;
            6: return 16'h4000;
            default: return 16'hC000;
        endcase
    endfunction

    task automatic check(string tag);
        logic [39:0] e_acc;
        logic [31:0] e32;
        logic [15:0] e16;
        longint      r;
        e_acc = m_acc[39:0];
        if (sat_en && oor32(m_acc)) e32 = (m_acc > 0) ? 32'h7FFFFFFF : 32'h80000000;
        else                        e32 = m_acc[31:0];
        r = m_acc + (rnd_en ? 64'sd32768 : 64'sd0);
        if (sat_en && oor32(r)) e16 = (r > 0) ? 16'h7FFF : 16'h8000;
        else                    e16 = r[31:16];
        vectors++;
        if (acc !== e_acc) begin
            miscmp++;
            $display("FAIL %s R2 acc act=%h exp=%h", tag, acc, e_acc);
        end
        if (ovf !== m_ovf) begin
            miscmp++;
            $display("FAIL %s R6 ovf act=%b exp=%b", tag, ovf, m_ovf);
        end
        if (ext32 !== e32) begin
            miscmp++;
            $display("FAIL %s R7 ext32 act=%h exp=%h", tag, ext32, e32);
        end
        if (ext16 !== e16) begin
            miscmp++;
            $display("FAIL %s R8/R9 ext16 act=%h exp=%h", tag, ext16, e16);
        end
    endtask

    // Check the current outputs, then drive the next operation and advance the model.
    task automatic step(string tag, bit v, bit c, logic [1:0] o, bit as, bit bs,
                        logic [15:0] ia, logic [15:0] ib, bit rn, bit sa);
        longint va;
        longint vb;
        longint p;
        @(negedge clk);
        check(tag);
        in_valid = v; clr = c; op = o; a_sgn = as; b_sgn = bs;
        a = ia; b = ib; rnd_en = rn; sat_en = sa;
        va = as ? longint'($signed(ia)) : longint'({1'b0, ia});
        vb = bs ? longint'($signed(ib)) : longint'({1'b0, ib});
        p  = va * vb;
        if (c) begin
            m_acc = 0;
            m_ovf = 0;
        end else if (v) begin
            case (o)
                2'b00: m_acc = sx40(p);
                2'b01: m_acc = sx40(m_acc + p);
                2'b10: m_acc = sx40(m_acc - p);
                default: ;
            endcase
            if (oor32(m_acc)) m_ovf = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset");
        rst_n = 1'b1;

        // R1, R2, R10: sweep of corner operands, sign modes, op codes and read-out
        // options, back to back, with idle cycles (R3) and clears (R4) mixed in.
        for (int i = 0; i < 1024; i++) begin
            step("R1 sweep", (i % 7) != 3, (i % 97) == 50, 2'(i >> 8),
                 i[6], i[7], corner(i % 8), corner((i >> 3) % 8),
                 i[0] ^ i[4], i[1] | i[8]);
        end

        // R4: clear overrides a valid load.
        step("R4 clr", 1, 1, 2'b00, 0, 0, 16'hFFFF, 16'hFFFF, 0, 0);
        // R3: idle cycles after a load.
        step("R3 load", 1, 0, 2'b00, 1, 1, 16'h8000, 16'h8000, 0, 0);
        for (int i = 0; i < 4; i++)
            step("R3 idle", 0, 0, 2'b00, 0, 0, 16'hFFFF, 16'hFFFF, i[0], i[1]);

        // R8: positive and negative ties.
        step("R8 tie", 1, 0, 2'b00, 0, 0, 16'h0001, 16'h8000, 1, 0);
        step("R8 tie", 1, 0, 2'b00, 1, 0, 16'hFFFF, 16'h8000, 1, 0);
        step("R8 tie", 0, 0, 2'b00, 0, 0, 16'h0000, 16'h0000, 1, 1);

        // R9: build 0x7FFF8000 so that rounding carries out of range.
        step("R9 build", 1, 1, 2'b00, 0, 0, 16'h0000, 16'h0000, 0, 0);
        step("R9 build", 1, 0, 2'b00, 0, 0, 16'h7FFF, 16'hFFFF, 0, 0);
        step("R9 build", 1, 0, 2'b01, 0, 0, 16'hFFFF, 16'h0001, 0, 0);
        step("R9 rnd", 0, 0, 2'b00, 0, 0, 16'h0000, 16'h0000, 1, 1);
        step("R9 rnd", 0, 0, 2'b00, 0, 0, 16'h0000, 16'h0000, 1, 0);
        step("R9 rnd", 0, 0, 2'b00, 0, 0, 16'h0000, 16'h0000, 0, 1);

        // R5, R6: long runs through the guard bits and past the 40-bit wrap.
        step("R5 clr", 1, 1, 2'b00, 0, 0, 16'h0000, 16'h0000, 0, 0);
        for (int i = 0; i < 200; i++)
            step("R5 add", 1, 0, 2'b01, 0, 0, 16'hFFFF, 16'hFFFF, i[0], i[1]);
        for (int i = 0; i < 400; i++)
            step("R5 sub", 1, 0, 2'b10, 0, 0, 16'hFFFF, 16'hFFFF, i[1], i[0]);
        step("R6 clr", 1, 1, 2'b01, 0, 0, 16'hFFFF, 16'hFFFF, 0, 1);
        step("R6 after", 0, 0, 2'b00, 0, 0, 16'h0000, 16'h0000, 0, 1);
        @(negedge clk);
        check("R6 final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule